// File: doc/BRIEF.md
# Halted-Core Debug Command Sequencer

This block sits between a debug host and a processor core that is stopped in its debug state. The host sends one 9-bit command word at a time. The block splits the word into three parts: a go flag, an exit flag and a 7-bit register select. It then runs the register access that the select names. After the access it drives the core handshakes for a single step, for the execution of an injected instruction, or for leaving debug state.

The meaning of go and exit depends on the select:
- For an ordinary register, go gives a single step after the access.
- The no-register code skips the access.
- A write to the injection register turns the step into execution of the written instruction.
- Adding exit makes the core resume normal running once the step is over, instead of halting again.

The block also keeps a 32-bit read-only status word. It holds sticky debug-reason bits, a busy bit and a mirror of the core's debug state.

Top module: `dbg_cmd_seq`

## Requirements
- R1: The command word is decoded as follows: bit 8 is go, bit 7 is exit, and bits 6..0 are the register select. While an access runs, `reg_sel` shows the select of the accepted word and `reg_wdata` shows its write data.
- R2: For any select other than the no-register code (default 7'h7F), `reg_req` rises in the cycle after the command is accepted. It stays high until a cycle with `reg_ack` high, and drops in the next cycle. `reg_we` equals the command's write flag. No step or exit request is issued before the acknowledge. The no-register code gives no `reg_req` at all.
- R3: With go set and exit clear, the block drives exactly one one-cycle `step_req` pulse after the access. It then waits for `step_done` and returns to idle with the core still in debug state.
- R4: With go and exit both set, the step is followed by `exit_req`. `exit_req` is held high until `in_debug` is low.
- R5: A write with go set to the injection select (default 7'h7E) drives `step_inject` high during the `step_req` pulse. Without exit the block then idles. With exit it then raises `exit_req`. A read of that select gives an ordinary step.
- R6: With exit set and go clear, `exit_req` follows the access without any step. With the no-register code, `exit_req` follows acceptance directly.
- R7: With go and exit both clear, only the access is performed. The block is idle again in the cycle after `reg_ack`.
- R8: `cmd_busy` is high from the cycle after acceptance until the sequence ends. A `cmd_valid` seen while busy raises `cmd_reject` in that same cycle and is otherwise ignored.
- R9: The status word is laid out as follows: bit 31 is busy, bit 30 mirrors `in_debug`, bits NREASON-1..0 (default 8) are the reason bits, and every other bit reads zero.
- R10: A high bit on `dbg_evt` sets the matching reason bit at the next clock edge, also while the core is already in debug state. The bit then stays set.
- R11: All reason bits clear at the edge after `in_debug` falls, or at the edge after a `dis_clr` pulse. An event in the same cycle as either clear condition still leaves its bit set.
- R12: While reset is active, all request, busy and reject outputs are low and the reason bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 9 | Go, exit and register select |
| cmd_wr | input | 1 | 1 = write access, 0 = read |
| cmd_wdata | input | 32 | Write data for the access |
| cmd_busy | output | 1 | Sequence in progress |
| cmd_reject | output | 1 | Command refused because busy |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_sel | output | 7 | Register being accessed |
| reg_wdata | output | 32 | Data for the write |
| reg_ack | input | 1 | Access completed |
| step_req | output | 1 | One-cycle request to run one instruction |
| step_inject | output | 1 | The step runs the injected instruction |
| step_done | input | 1 | The instruction has completed |
| exit_req | output | 1 | Request to leave debug state |
| in_debug | input | 1 | Core is halted in debug state |
| dbg_evt | input | 8 | Debug-reason events, one per bit |
| dis_clr | input | 1 | Software cleared the debug-interrupt flag |
| status | output | 32 | Read-only status word |

## Verification
Two things can meet in one cycle: a reason event setting its bit, and a clear of all reason bits. The clear comes either from a `dis_clr` pulse or from the core dropping `in_debug` at the end of an exit sequence. The bench drives an event together with `dis_clr` from its stimulus. Its core model can also raise an event in the very cycle it lets `in_debug` fall. A reference model updates the reason bits with set-over-clear priority and compares the whole status word on every clock. Commands are also sent back to back, so that a rejection falls while an access is still waiting for its acknowledge.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_ACCESS = 3'd1,
    SQ_STEP   = 3'd2,
    SQ_WAIT   = 3'd3,
    SQ_EXIT   = 3'd4
  } seq_state_e;

  // Where a sequence goes once its register access (if any) is finished.
  function automatic seq_state_e after_access(input logic go, input logic ex);
    if (go)      return SQ_STEP;
    else if (ex) return SQ_EXIT;
    else         return SQ_IDLE;
  endfunction

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode #(
  parameter int SEL_W = 7,
  parameter logic [SEL_W-1:0] NOREG_SEL = {SEL_W{1'b1}},
  parameter logic [SEL_W-1:0] INJ_SEL   = {{(SEL_W-1){1'b1}}, 1'b0}
) (
  input  logic [SEL_W+1:0] word,
  input  logic             wr,
  output logic             go,
  output logic             ex,
  output logic [SEL_W-1:0] sel,
  output logic             no_reg,
  output logic             inject
);
  // Field positions: go on top, exit below it, select in the low bits.
  always_comb begin
    go     = word[SEL_W+1];
    ex     = word[SEL_W];
    sel    = word[SEL_W-1:0];
    no_reg = (word[SEL_W-1:0] == NOREG_SEL);
    inject = (word[SEL_W-1:0] == INJ_SEL) && wr;
  end
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
#(
  parameter int SEL_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              go,
  input  logic              ex,
  input  logic              no_reg,
  input  logic              inject,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reg_ack,
  input  logic              step_done,
  input  logic              in_debug,
  output logic              busy,
  output logic              reg_req,
  output logic              reg_we,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              step_req,
  output logic              step_inject,
  output logic              exit_req
);
  seq_state_e        st_q, st_d;
  logic              accept;
  logic              go_q, ex_q, inj_q, we_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] wd_q;

  assign accept = cmd_valid && (st_q == SQ_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:   if (cmd_valid) st_d = no_reg ? after_access(go, ex) : SQ_ACCESS;
      SQ_ACCESS: if (reg_ack)   st_d = after_access(go_q, ex_q);
      SQ_STEP:                  st_d = SQ_WAIT;
      SQ_WAIT:   if (step_done) st_d = ex_q ? SQ_EXIT : SQ_IDLE;
      SQ_EXIT:   if (!in_debug) st_d = SQ_IDLE;
      default:                  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // Command fields, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      ex_q  <= 1'b0;
      inj_q <= 1'b0;
      we_q  <= 1'b0;
      sel_q <= '0;
      wd_q  <= '0;
    end else if (accept) begin
      go_q  <= go;
      ex_q  <= ex;
      inj_q <= inject;
      we_q  <= wr;
      sel_q <= sel;
      wd_q  <= wdata;
    end
  end

  always_comb begin
    busy        = (st_q != SQ_IDLE);
    reg_req     = (st_q == SQ_ACCESS);
    reg_we      = reg_req && we_q;
    reg_sel     = sel_q;
    reg_wdata   = wd_q;
    step_req    = (st_q == SQ_STEP);
    step_inject = step_req && inj_q;
    exit_req    = (st_q == SQ_EXIT);
  end
endmodule

// File: rtl/dbg_reason_status.sv
module dbg_reason_status #(
  parameter int NREASON  = 8,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREASON-1:0]  evt,
  input  logic                dis_clr,
  input  logic                in_debug,
  input  logic                busy,
  output logic [STATUS_W-1:0] status
);
  localparam int PAD_W = STATUS_W - 2 - NREASON;

  logic [NREASON-1:0] reason_q, reason_d;
  logic               dbg_q;
  logic               clr;

  // The clear is applied first and the events are ORed in after it,
  // so an event in a clearing cycle is kept.
  always_comb begin
    clr      = dis_clr || (dbg_q && !in_debug);
    reason_d = (clr ? '0 : reason_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reason_q <= '0;
      dbg_q    <= 1'b0;
    end else begin
      reason_q <= reason_d;
      dbg_q    <= in_debug;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign status = {busy, in_debug, {PAD_W{1'b0}}, reason_q};
    end else begin : g_nopad
      assign status = {busy, in_debug, reason_q};
    end
  endgenerate
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq #(
  parameter int SEL_W   = 7,
  parameter int DATA_W  = 32,
  parameter int NREASON = 8,
  parameter logic [SEL_W-1:0] NOREG_SEL = {SEL_W{1'b1}},
  parameter logic [SEL_W-1:0] INJ_SEL   = {{(SEL_W-1){1'b1}}, 1'b0}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [SEL_W+1:0]   cmd_word,
  input  logic               cmd_wr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  output logic               cmd_busy,
  output logic               cmd_reject,
  output logic               reg_req,
  output logic               reg_we,
  output logic [SEL_W-1:0]   reg_sel,
  output logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_ack,
  output logic               step_req,
  output logic               step_inject,
  input  logic               step_done,
  output logic               exit_req,
  input  logic               in_debug,
  input  logic [NREASON-1:0] dbg_evt,
  input  logic               dis_clr,
  output logic [31:0]        status
);
  localparam int STATUS_W = 32;

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic             d_go, d_ex, d_noreg, d_inj;
  logic [SEL_W-1:0] d_sel;

  dbg_cmd_decode #(.SEL_W(SEL_W), .NOREG_SEL(NOREG_SEL), .INJ_SEL(INJ_SEL)) u_dec (
    .word(cmd_word), .wr(cmd_wr), .go(d_go), .ex(d_ex), .sel(d_sel),
    .no_reg(d_noreg), .inject(d_inj)
  );

  dbg_seq_fsm #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid),
    .go(d_go), .ex(d_ex), .no_reg(d_noreg), .inject(d_inj), .sel(d_sel),
    .wr(cmd_wr), .wdata(cmd_wdata), .reg_ack(reg_ack), .step_done(step_done),
    .in_debug(in_debug), .busy(cmd_busy), .reg_req(reg_req), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .step_req(step_req),
    .step_inject(step_inject), .exit_req(exit_req)
  );

  dbg_reason_status #(.NREASON(NREASON), .STATUS_W(STATUS_W)) u_rsn (
    .clk(clk), .rst_n(rst_sync_n), .evt(dbg_evt), .dis_clr(dis_clr),
    .in_debug(in_debug), .busy(cmd_busy), .status(status)
  );

  assign cmd_reject = cmd_valid && cmd_busy;
endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk #(
  parameter int NREASON = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_busy,
  input logic               cmd_reject,
  input logic               reg_req,
  input logic               reg_ack,
  input logic               step_req,
  input logic               exit_req,
  input logic               in_debug,
  input logic [NREASON-1:0] dbg_evt,
  input logic [31:0]        status
);
  // R3: a step request lasts one cycle only
  p_step_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |=> !step_req);

  // R2: an acknowledged access request is withdrawn in the next cycle
  p_ack_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ack) |=> !reg_req);

  // R2: the access, step and exit requests never overlap
  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_req, step_req, exit_req}));

  // R4: the exit request is held until the core has left debug state
  p_exit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && in_debug) |=> exit_req);

  // R8: a rejection only happens while a sequence is running
  p_reject_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> cmd_busy);

  // R11: an event is never lost, even to a clear in the same cycle
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[NREASON-1:0] & $past(dbg_evt)) == $past(dbg_evt)));
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk #(.NREASON(NREASON)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_busy(cmd_busy), .cmd_reject(cmd_reject),
  .reg_req(reg_req), .reg_ack(reg_ack), .step_req(step_req), .exit_req(exit_req),
  .in_debug(in_debug), .dbg_evt(dbg_evt), .status(status)
);

// File: tb/dbg_cmd_seq_test.sv
module dbg_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [8:0]  cmd_word = '0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        reg_ack = 1'b0;
  logic        step_done = 1'b0;
  logic        in_debug = 1'b1;
  logic [7:0]  stim_evt = '0;
  logic [7:0]  core_evt = '0;
  logic [7:0]  dbg_evt;
  logic        dis_clr = 1'b0;
  logic        cmd_busy, cmd_reject, reg_req, reg_we, step_req, step_inject, exit_req;
  logic [6:0]  reg_sel;
  logic [31:0] reg_wdata, status;

  int total = 0;
  int bad = 0;
  bit collide = 1'b0;

  assign dbg_evt = stim_evt | core_evt;
  always #4 clk = ~clk;

  dbg_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
    .cmd_reject(cmd_reject), .reg_req(reg_req), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .step_req(step_req), .step_inject(step_inject), .step_done(step_done),
    .exit_req(exit_req), .in_debug(in_debug), .dbg_evt(dbg_evt),
    .dis_clr(dis_clr), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Core model: acknowledges accesses, completes steps, and leaves and re-enters debug state.
  int acnt = 0, spend = 0, ecnt = 0, off = 0;
  always @(negedge clk) begin
    core_evt <= '0;
    if (reg_ack) reg_ack <= 1'b0;
    else if (reg_req) begin
      acnt = acnt + 1;
      if (acnt == 2) begin reg_ack <= 1'b1; acnt = 0; end
    end
    step_done <= 1'b0;
    if (step_req) spend = 3;
    else if (spend > 0) begin
      spend = spend - 1;
      if (spend == 1) step_done <= 1'b1;
    end
    if (off > 0) begin
      off = off - 1;
      if (off == 0) in_debug <= 1'b1;
    end else if (exit_req && in_debug) begin
      ecnt = ecnt + 1;
      if (ecnt == 2) begin
        in_debug <= 1'b0;
        off = 3;
        ecnt = 0;
        if (collide) core_evt <= 8'h04;
      end
    end
  end

  // Reference model, compared against the outputs on every rising edge.
  int ph = 0, rcnt = 0;
  bit m_go, m_ex, m_inj, m_we, pdbg;
  logic [6:0]  m_sel;
  logic [31:0] m_wd;
  logic [7:0]  m_rsn = '0;
  always @(posedge clk) begin
    chk("R8 busy", cmd_busy, ph != 0);
    chk("R8 reject", cmd_reject, cmd_valid && ph != 0);
    chk("R2 reg_req", reg_req, ph == 1);
    chk("R2 reg_we", reg_we, ph == 1 && m_we);
    if (ph == 1) begin
      chk("R1 reg_sel", reg_sel, m_sel);
      chk("R1 reg_wdata", reg_wdata, m_wd);
    end
    chk("R3 step_req", step_req, ph == 2);
    chk("R5 step_inject", step_inject, ph == 2 && m_inj);
    chk("R4 exit_req", exit_req, ph == 4);
    chk("R9 status", status, {ph != 0, in_debug, 22'd0, m_rsn});
    if (!rst_n) begin
      ph = 0; rcnt = 0; m_rsn = '0; pdbg = 1'b0;
    end else if (rcnt < 2) rcnt++;
    else begin
      if (dis_clr || (pdbg && !in_debug)) m_rsn = '0;
      m_rsn = m_rsn | dbg_evt;
      pdbg = in_debug;
      case (ph)
        0: if (cmd_valid) begin
             m_go = cmd_word[8]; m_ex = cmd_word[7]; m_sel = cmd_word[6:0];
             m_we = cmd_wr; m_wd = cmd_wdata;
             m_inj = (cmd_word[6:0] == 7'h7E) && cmd_wr;
             if (cmd_word[6:0] == 7'h7F) ph = m_go ? 2 : (m_ex ? 4 : 0);
             else ph = 1;
           end
        1: if (reg_ack) ph = m_go ? 2 : (m_ex ? 4 : 0);
        2: ph = 3;
        3: if (step_done) ph = m_ex ? 4 : 0;
        4: if (!in_debug) ph = 0;
        default: ph = 0;
      endcase
    end
  end

  task automatic send(input bit go, input bit ex, input logic [6:0] sel,
                      input bit wr, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = {go, ex, sel}; cmd_wr = wr; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (!cmd_busy && in_debug && off == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic evt_pulse(input logic [7:0] e, input bit clr);
    @(negedge clk);
    stim_evt = e; dis_clr = clr;
    @(negedge clk);
    stim_evt = '0; dis_clr = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs while reset is held
    chk("R12 reset busy", cmd_busy, 0);
    chk("R12 reset reqs", {reg_req, step_req, exit_req, cmd_reject}, 0);
    chk("R12 reset reasons", status[7:0], 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    send(0, 0, 7'h05, 1, 32'hA5A5_0001);    // R7 access only
    send(0, 1, 7'h03, 0, 32'h0);            // R6 read, then exit
    send(1, 0, 7'h11, 1, 32'h1234_5678);    // R3 single step
    send(1, 0, 7'h7F, 0, 32'h0);            // R3 step without access
    send(1, 1, 7'h22, 1, 32'hDEAD_BEEF);    // R4 step, then leave
    send(1, 0, 7'h7E, 1, 32'h0000_00C3);    // R5 inject and stay
    send(1, 1, 7'h7E, 1, 32'h0000_00C4);    // R5 inject and leave
    send(1, 0, 7'h7E, 0, 32'h0);            // R5 read of injection select: plain step
    send(0, 1, 7'h7F, 0, 32'h0);            // R6 exit without access
    // R8: a second command while the first still waits for its acknowledge
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = {2'b00, 7'h09}; cmd_wr = 1'b1; cmd_wdata = 32'h1;
    @(negedge clk);
    cmd_word = {2'b11, 7'h7F};
    chk("R8 reject seen", cmd_reject, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 rejected command had no effect", {cmd_busy, exit_req, in_debug}, 3'b001);
    // R10: events while halted; R11: clears and set-over-clear
    evt_pulse(8'h81, 0);
    @(negedge clk);
    chk("R10 sticky reasons", status[7:0], 8'h81);
    evt_pulse(8'h10, 0);
    @(negedge clk);
    chk("R10 more reasons", status[7:0], 8'h91);
    evt_pulse(8'h00, 1);
    @(negedge clk);
    chk("R11 clear by dis_clr", status[7:0], 8'h00);
    evt_pulse(8'h03, 0);
    evt_pulse(8'h20, 1);
    @(negedge clk);
    chk("R11 set wins over dis_clr", status[7:0], 8'h20);
    evt_pulse(8'h40, 0);
    collide = 1'b1;
    send(0, 1, 7'h7F, 0, 32'h0);
    collide = 1'b0;
    chk("R11 set wins over leaving debug", status[7:0], 8'h04);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule